// File: doc/BRIEF.md
# Boot Remap and Write-Protect Controller

This block decides, for every bus access, which memory answers it. The main concern is the low address window that holds the exception vectors. While the active-low reset pin is held, the block samples a boot-select pin. That level chooses the non-volatile memory that the low window decodes to after reset. The choice is either 16-bit external memory on chip select 0, or a build-time alternative: 8-bit external memory on chip select 0, 32-bit internal ROM, or the 32-bit internal emulation SRAM.

Software then uses a small register write port for two things. It can set a remap flag, which moves the low window onto the internal primary SRAM and opens the decode of external chip selects 1 to 7. Only reset clears that flag. Software can also lift or restore the write protection of the emulation SRAM, which is armed again by every reset.

The decoder works on the top address bits, which form a region number. Each access either produces one one-hot target select or an abort. An abort happens on an undefined region, or on a write to the emulation SRAM while it is protected. Abort and selects are combinational and stay aligned with the access valid strobe.

Top module: `boot_remap_ctrl`

## Requirements
- R1: With the boot pin at 0 in the last reset cycle, a low-window access (address region 0, region = acc_addr[23:20]) selects chip select 0 (tgt_sel bit 3), and boot_width reads 1 (code 0 = 8-bit, 1 = 16-bit, 2 = 32-bit).
- R2: With the boot pin at 1 and the default build (alternative source = emulation SRAM), a low-window read selects the emulation SRAM (tgt_sel bit 2), and boot_width reads 2.
- R3: The boot level kept is the one the pin shows in the final clock cycle of the reset window, even when the pin toggles earlier in that window.
- R4: Once reset is released, changes on boot_pin have no effect on the decode or on boot_width.
- R5: A register write with cfg_sel = 0 and cfg_wdata bit 0 = 1 sets the remap flag. From the next cycle on, low-window accesses select the primary SRAM (tgt_sel bit 1).
- R6: The remap flag ignores register writes that carry bit 0 = 0, as well as writes to the other register. Only a reset clears it.
- R7: Regions 9 to 15 map to chip selects 1 to 7 (tgt_sel bits 4 to 10) only after remap. Before remap, an access there aborts and selects nothing.
- R8: After every reset the emulation SRAM (region 2, and the low window when it decodes there) is write-protected. A write to it aborts with no select, while reads go through.
- R9: A register write with cfg_sel = 1 and bit 0 = 1 removes the protection. The same write with bit 0 = 0 restores it.
- R10: Regions 3 to 7 are undefined in the default build, and any access to them aborts.
- R11: tgt_sel is one-hot or zero. With acc_valid low, tgt_sel is zero and acc_abort is low. An abort never comes with a select.
- R12: Region 1 always selects the primary SRAM and region 8 always selects chip select 0, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin, sampled synchronously |
| boot_pin | input | 1 | Boot-select level, sampled only while reset is held |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 remap, 1 memory mode |
| cfg_wdata | input | 8 | Register write data, bit 0 used |
| acc_valid | input | 1 | Bus access strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 24 | Access address |
| tgt_sel | output | 11 | One-hot target: bit 0 ROM, 1 primary SRAM, 2 emulation SRAM, 3..10 chip selects 0..7 |
| boot_width | output | 2 | Data width of the boot memory |
| acc_abort | output | 1 | Abort, combinational with acc_valid |

## Verification
The assertions assume that acc_write and acc_addr are meaningful only while acc_valid is high. They also assume that register writes and accesses are not issued while reset is held, and that the boot pin is settled before the clock edge that samples it. The bench changes every input just after the falling clock edge and deasserts its strobes before reset. It reads the combinational outputs one nanosecond later, well before the next rising edge, so each check sees the state left by the last rising edge together with the current inputs.

// File: rtl/brc_pkg.sv
package brc_pkg;

   // Boot memory width codes seen on boot_width
   typedef enum logic [1:0] {
      BW_8  = 2'd0,
      BW_16 = 2'd1,
      BW_32 = 2'd2
   } bwidth_e;

   // Alternative boot source chosen at build time for boot level 1
   localparam int ALT_EXT8 = 0;
   localparam int ALT_ROM  = 1;
   localparam int ALT_EMU  = 2;

   // Bit positions inside the one-hot target vector
   localparam int TGT_ROM = 0;
   localparam int TGT_PRI = 1;
   localparam int TGT_EMU = 2;
   localparam int TGT_CS0 = 3;

   // Register select codes on cfg_sel
   localparam logic SEL_REMAP = 1'b0;
   localparam logic SEL_MODE  = 1'b1;

endpackage

// File: rtl/brc_boot_sampler.sv
module brc_boot_sampler
   import brc_pkg::*;
#(
   parameter int WIN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boot_pin,
   output logic boot_lvl
);

   if (WIN < 1) begin : g_bad_win
      $error("brc_boot_sampler: WIN must be at least 1");
   end

   // Follows the pin on every cycle that reset is held. The last of the
   // window cycles therefore wins; outside reset the level is frozen.
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= boot_pin;
   end

   assign boot_lvl = lvl_q;

   // R4: no change of the latched level while out of reset
   a_r4_boot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(boot_lvl));

endmodule

// File: rtl/brc_ctrl_regs.sv
module brc_ctrl_regs
   import brc_pkg::*;
#(
   parameter int CFG_DW     = 8,
   parameter int REMAP_BIT  = 0,
   parameter int UNPROT_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic              remap,
   output logic              protect
);

   if (REMAP_BIT >= CFG_DW || UNPROT_BIT >= CFG_DW) begin : g_bad_bits
      $error("brc_ctrl_regs: control bit outside the data width");
   end

   logic remap_q, prot_q;
   logic set_remap, wr_mode;
   logic unused_wdata;

   assign set_remap    = cfg_wr && (cfg_sel == SEL_REMAP) && cfg_wdata[REMAP_BIT];
   assign wr_mode      = cfg_wr && (cfg_sel == SEL_MODE);
   assign unused_wdata = ^cfg_wdata;

   // Remap: sticky, set by software, cleared by reset only
   always_ff @(posedge clk) begin
      if (!rst_n)         remap_q <= 1'b0;
      else if (set_remap) remap_q <= 1'b1;
   end

   // Protection: armed by reset, toggled by the mode register
   always_ff @(posedge clk) begin
      if (!rst_n)       prot_q <= 1'b1;
      else if (wr_mode) prot_q <= ~cfg_wdata[UNPROT_BIT];
   end

   assign remap   = remap_q;
   assign protect = prot_q;

   // R5: a set request is visible on the next cycle
   a_r5_remap_set: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == SEL_REMAP && cfg_wdata[REMAP_BIT]) |=> remap);
   // R6: once set, remap stays set until reset
   a_r6_remap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(remap) |-> remap);
   // R8: protection armed and remap clear right after reset
   a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (protect && !remap));
   // R9: unprotect command clears protection on the next cycle
   a_r9_unprotect: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_sel == SEL_MODE && cfg_wdata[UNPROT_BIT]) |=> !protect);

endmodule

// File: rtl/brc_addr_decode.sv
module brc_addr_decode
   import brc_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int REGION_BITS = 4,
   parameter int NUM_CS      = 8,
   parameter int EXT_BASE    = 8,
   parameter int LOW_REG     = 0,
   parameter int PRI_REG     = 1,
   parameter int EMU_REG     = 2,
   parameter int ROM_REG     = 3,
   parameter int BOOT_ALT    = ALT_EMU,
   localparam int NUM_TGT    = TGT_CS0 + NUM_CS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic               remap,
   input  logic               protect,
   input  logic               boot_lvl,
   output logic [NUM_TGT-1:0] tgt_sel,
   output logic               acc_abort,
   output logic [1:0]         boot_width
);

   localparam bit HAS_ROM = (BOOT_ALT == ALT_ROM);
   localparam bit HAS_EMU = (BOOT_ALT == ALT_EMU);
   localparam int ALT_TGT = HAS_ROM ? TGT_ROM : (HAS_EMU ? TGT_EMU : TGT_CS0);

   logic [REGION_BITS-1:0] region;
   int unsigned            reg_i;
   logic [NUM_TGT-1:0]     hit;
   logic                   undef, wp_hit;
   bwidth_e                alt_w;
   logic                   unused_addr;

   assign region      = acc_addr[ADDR_W-1 -: REGION_BITS];
   assign reg_i       = 32'(region);
   assign unused_addr = ^acc_addr[ADDR_W-REGION_BITS-1:0];

   // Width of the alternative boot source depends on the build variant
   if (BOOT_ALT == ALT_EXT8) begin : g_alt_ext8
      assign alt_w = BW_8;
   end else begin : g_alt_int32
      assign alt_w = BW_32;
   end

   assign boot_width = boot_lvl ? alt_w : BW_16;

   always_comb begin
      hit   = '0;
      undef = 1'b0;
      if (reg_i == LOW_REG) begin
         if (remap)         hit[TGT_PRI] = 1'b1;
         else if (boot_lvl) hit[ALT_TGT] = 1'b1;
         else               hit[TGT_CS0] = 1'b1;
      end else if (reg_i == PRI_REG) begin
         hit[TGT_PRI] = 1'b1;
      end else if (reg_i == EMU_REG) begin
         if (HAS_EMU) hit[TGT_EMU] = 1'b1;
         else         undef = 1'b1;
      end else if (reg_i == ROM_REG) begin
         if (HAS_ROM) hit[TGT_ROM] = 1'b1;
         else         undef = 1'b1;
      end else begin
         undef = 1'b1;
         for (int c = 0; c < NUM_CS; c++) begin
            if (reg_i == EXT_BASE + c) begin
               // chip select 0 always routed, the others only after remap
               if (c == 0 || remap) begin
                  hit[TGT_CS0 + c] = 1'b1;
                  undef            = 1'b0;
               end
            end
         end
      end
   end

   assign wp_hit    = acc_write && protect && hit[TGT_EMU];
   assign acc_abort = acc_valid && (undef || wp_hit);
   assign tgt_sel   = (acc_valid && !acc_abort) ? hit : '0;

   // R11: at most one target, none while idle, none with an abort
   a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel));
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (tgt_sel == '0 && !acc_abort));
   a_r11_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
      acc_abort |-> (tgt_sel == '0));
   // R7: upper chip selects stay quiet before remap
   a_r7_cs_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !remap) |-> (tgt_sel[NUM_TGT-1:TGT_CS0+1] == '0));
   // R8: protected write to the emulation bank region always aborts
   a_r8_wp_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && protect && reg_i == EMU_REG) |-> acc_abort);
   // R5: remapped low window lands on the primary SRAM
   a_r5_low_primary: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && remap && reg_i == LOW_REG) |-> tgt_sel[TGT_PRI]);

endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl
   import brc_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int REGION_BITS = 4,
   parameter int NUM_CS      = 8,
   parameter int EXT_BASE    = 8,
   parameter int BOOT_ALT    = ALT_EMU,
   parameter int SAMPLE_WIN  = 10,
   parameter int CFG_DW      = 8,
   localparam int NUM_TGT    = TGT_CS0 + NUM_CS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               boot_pin,
   input  logic               cfg_wr,
   input  logic               cfg_sel,
   input  logic [CFG_DW-1:0]  cfg_wdata,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   output logic [NUM_TGT-1:0] tgt_sel,
   output logic [1:0]         boot_width,
   output logic               acc_abort
);

   localparam int NUM_REGIONS = 1 << REGION_BITS;

   if (ADDR_W <= REGION_BITS) begin : g_bad_addr
      $error("boot_remap_ctrl: ADDR_W must exceed REGION_BITS");
   end
   if (NUM_CS < 2 || EXT_BASE + NUM_CS > NUM_REGIONS || EXT_BASE < 4) begin : g_bad_cs
      $error("boot_remap_ctrl: chip select regions do not fit the map");
   end
   if (BOOT_ALT < ALT_EXT8 || BOOT_ALT > ALT_EMU) begin : g_bad_alt
      $error("boot_remap_ctrl: unknown BOOT_ALT variant");
   end

   logic boot_lvl, remap, protect;

   brc_boot_sampler #(.WIN(SAMPLE_WIN)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .boot_pin (boot_pin),
      .boot_lvl (boot_lvl)
   );

   brc_ctrl_regs #(.CFG_DW(CFG_DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .remap     (remap),
      .protect   (protect)
   );

   brc_addr_decode #(
      .ADDR_W      (ADDR_W),
      .REGION_BITS (REGION_BITS),
      .NUM_CS      (NUM_CS),
      .EXT_BASE    (EXT_BASE),
      .BOOT_ALT    (BOOT_ALT)
   ) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_addr   (acc_addr),
      .remap      (remap),
      .protect    (protect),
      .boot_lvl   (boot_lvl),
      .tgt_sel    (tgt_sel),
      .acc_abort  (acc_abort),
      .boot_width (boot_width)
   );

endmodule

// File: tb/boot_remap_ctrl_tb.sv
`timescale 1ns/1ps
module boot_remap_ctrl_tb;

   localparam real HALF = 2.5;   // 200 MHz
   localparam logic [10:0] S_NONE = 11'd0;
   localparam logic [10:0] S_PRI  = 11'b000_0000_0010;
   localparam logic [10:0] S_EMU  = 11'b000_0000_0100;
   localparam logic [10:0] S_CS0  = 11'b000_0000_1000;
   localparam logic [10:0] S_CS1  = 11'b000_0001_0000;
   localparam logic [10:0] S_CS7  = 11'b100_0000_0000;

   // {req[3:0], region[3:0], write, abort, sel[10:0]}
   // state: boot level 1, protected, not remapped
   localparam logic [20:0] VEC [12] = '{
      {4'd2,  4'd0,  1'b0, 1'b0, S_EMU},  // R2 low read
      {4'd8,  4'd0,  1'b1, 1'b1, S_NONE}, // R8 low write protected
      {4'd12, 4'd1,  1'b0, 1'b0, S_PRI},  // R12
      {4'd12, 4'd1,  1'b1, 1'b0, S_PRI},  // R12
      {4'd8,  4'd2,  1'b0, 1'b0, S_EMU},  // R8 read allowed
      {4'd8,  4'd2,  1'b1, 1'b1, S_NONE}, // R8 write aborts
      {4'd10, 4'd3,  1'b0, 1'b1, S_NONE}, // R10
      {4'd10, 4'd5,  1'b1, 1'b1, S_NONE}, // R10
      {4'd12, 4'd8,  1'b0, 1'b0, S_CS0},  // R12
      {4'd12, 4'd8,  1'b1, 1'b0, S_CS0},  // R12
      {4'd7,  4'd9,  1'b0, 1'b1, S_NONE}, // R7 before remap
      {4'd7,  4'd15, 1'b1, 1'b1, S_NONE}  // R7 before remap
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_pin = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = 8'd0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [23:0] acc_addr = 24'd0;
   logic [10:0] tgt_sel;
   logic [1:0]  boot_width;
   logic        acc_abort;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(HALF) clk = ~clk;

   boot_remap_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .boot_pin(boot_pin),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .tgt_sel(tgt_sel), .boot_width(boot_width), .acc_abort(acc_abort)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one access after a falling edge and check the combinational result
   task automatic access(input string req, input logic [3:0] region, input logic wr,
                         input logic exp_abort, input logic [10:0] exp_sel);
      @(negedge clk);
      acc_valid = 1'b1;
      acc_write = wr;
      acc_addr  = {region, 20'h0_5a3c};
      #1;
      check(req, {4'd0, acc_abort, tgt_sel}, {4'd0, exp_abort, exp_sel});
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
   endtask

   task automatic cfg_write(input logic sel, input logic [7:0] data);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_sel = sel;
      cfg_wdata = data;
      @(negedge clk);
      cfg_wr = 1'b0;
      cfg_wdata = 8'd0;
   endtask

   // Hold reset for 12 cycles with the pin following pat; pat[11] is last
   task automatic do_reset(input logic [11:0] pat);
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
         boot_pin = pat[i];
         @(negedge clk);
      end
      rst_n = 1'b1;
      boot_pin = ~pat[11];   // pin becomes a general I/O line (R4)
      @(negedge clk);
   endtask

   initial begin
      #(HALF * 2.0 * 100000.0);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: stable low boot level, reset state
      do_reset(12'h000);
      check("R1 boot width", {14'd0, boot_width}, 16'd1);
      check("R1 idle outputs", {4'd0, acc_abort, tgt_sel}, 16'd0);
      access("R1 low read", 4'd0, 1'b0, 1'b0, S_CS0);
      access("R1 low write", 4'd0, 1'b1, 1'b0, S_CS0);

      // R3: glitching pin, last sample is 1
      do_reset(12'b1000_1010_0110);
      check("R3 glitch to 1 width", {14'd0, boot_width}, 16'd2);
      // R4: pin now 0 after release, decode unchanged
      repeat (3) @(negedge clk);
      check("R4 pin ignored width", {14'd0, boot_width}, 16'd2);

      for (int v = 0; v < 12; v++) begin
         access($sformatf("R%0d vector %0d", VEC[v][20:17], v),
                VEC[v][16:13], VEC[v][12], VEC[v][11], VEC[v][10:0]);
      end

      // R11: idle strobe gives nothing even with a protected-write pattern
      @(negedge clk);
      acc_write = 1'b1;
      acc_addr = {4'd2, 20'd0};
      #1;
      check("R11 idle", {4'd0, acc_abort, tgt_sel}, 16'd0);
      acc_write = 1'b0;

      // R9: lift protection, then restore it
      cfg_write(1'b1, 8'h01);
      access("R9 emu write unprotected", 4'd2, 1'b1, 1'b0, S_EMU);
      access("R9 low write unprotected", 4'd0, 1'b1, 1'b0, S_EMU);
      cfg_write(1'b1, 8'h00);
      access("R9 protection restored", 4'd2, 1'b1, 1'b1, S_NONE);

      // R6: remap write with bit 0 clear does nothing
      cfg_write(1'b0, 8'hFE);
      access("R6 no remap on zero", 4'd0, 1'b0, 1'b0, S_EMU);

      // R5 / R7: remap on
      cfg_write(1'b0, 8'h01);
      access("R5 low to primary", 4'd0, 1'b0, 1'b0, S_PRI);
      access("R7 cs1 after remap", 4'd9, 1'b0, 1'b0, S_CS1);
      access("R7 cs7 after remap", 4'd15, 1'b1, 1'b0, S_CS7);

      // R6: clearing attempts ignored
      cfg_write(1'b0, 8'h00);
      cfg_write(1'b1, 8'h00);
      access("R6 remap sticky", 4'd0, 1'b0, 1'b0, S_PRI);

      // R6 / R8 / R3: reset clears remap, rearms protection, glitch ends at 0
      do_reset(12'b0111_0101_1001);
      check("R3 glitch to 0 width", {14'd0, boot_width}, 16'd1);
      access("R6 reset clears remap", 4'd0, 1'b0, 1'b0, S_CS0);
      access("R7 cs1 gated again", 4'd9, 1'b0, 1'b1, S_NONE);
      access("R8 protection rearmed", 4'd2, 1'b1, 1'b1, S_NONE);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule